// File: doc/BRIEF.md
# Packet Framer With Channel Marker

This block sits between a transaction-layer byte stream and a physical-layer byte codec. It has two independent directions. The transmit encoder takes payload bytes, with a flag marking the final byte of each packet. It wraps them in a start marker, a channel marker and channel number, and an end marker. It escapes every payload byte that would otherwise look like one of the four reserved codes. The end marker is sent ahead of the final payload byte, not after it, so a receiver knows that the next data byte closes the packet.

The receive decoder watches the incoming byte stream for a start marker, checks the channel field, removes escapes and hands the payload on. It marks the first byte of each packet with a first flag and the closing byte with a last flag. Packets addressed to any channel other than zero are consumed silently. A start marker that arrives inside a packet abandons that packet and begins a new one. Every port pair uses a valid/ready handshake.

Top module: `pkt_framer`

## Requirements
- R1: After reset, `tx_valid` and `m_valid` are low, and both `s_ready` and `rx_ready` are high.
- R2: The reserved codes are start 0x7A, end 0x7B, channel marker 0x7C and escape 0x7D. A transmitted packet is sent in this order: 0x7A, 0x7C, the channel byte, every payload byte except the final one, 0x7B, and then the final payload byte.
- R3: The transmitter always follows 0x7C with the channel byte 0x00.
- R4: Any transmitted payload byte in the range 0x7A to 0x7D is sent as 0x7D followed by that byte XOR 0x20. This also applies to the final byte after 0x7B, so a final 0x7A is sent as 0x7B 0x7D 0x5A.
- R5: A one-byte payload b is sent as 0x7A 0x7C 0x00 0x7B and then b, escaped if it needs to be.
- R6: The receiver strips the markers and the channel field and undoes escapes. A 0x7D followed by x yields x XOR 0x20. Payload bytes are delivered in the order they were sent.
- R7: On `m_data`, `m_first` is high only on the first payload byte after the channel field. `m_last` is high only on the first data byte (after any escape is undone) that follows 0x7B.
- R8: A received packet whose channel byte is not 0x00 produces no output. Reception resumes at the next 0x7A.
- R9: A 0x7A received inside a packet abandons that packet, and the following bytes are decoded as a new packet.
- R10: Received bytes outside a packet, meaning before a start marker or after a completed packet, produce no output.
- R11: On both outputs, while valid is high and ready is low, valid stays high and the data and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_data | input | 8 | Transmit payload byte |
| s_valid | input | 1 | Transmit payload byte valid |
| s_last | input | 1 | Marks the final payload byte of a packet |
| s_ready | output | 1 | Encoder accepts the payload byte |
| tx_data | output | 8 | Framed byte toward the physical codec |
| tx_valid | output | 1 | Framed byte valid |
| tx_ready | input | 1 | Physical codec accepts the framed byte |
| rx_data | input | 8 | Framed byte from the physical codec |
| rx_valid | input | 1 | Framed byte valid |
| rx_ready | output | 1 | Decoder accepts the framed byte |
| m_data | output | 8 | Decoded payload byte |
| m_valid | output | 1 | Decoded payload byte valid |
| m_first | output | 1 | First payload byte of a packet |
| m_last | output | 1 | Final payload byte of a packet |
| m_ready | input | 1 | Transaction side accepts the decoded byte |

## Verification
The assertions check, on every transmitted byte, the local grammar of the framed stream. After 0x7A must come 0x7C. After 0x7C must come the channel byte. After an escape must come a byte in 0x5A to 0x5D. The assertions also check that both outputs hold steady under backpressure. Whole-packet ordering, the position of the end marker relative to the final byte, and the receive-side behaviours can only be shown by the bench's scenarios, which compare complete streams against an encoding built in the bench. Those receive-side behaviours are the first and last flags, dropping on a non-zero channel, aborting on a new start marker, and ignoring stray bytes.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] SOP_CODE  = 8'h7A;
    localparam logic [BYTE_W-1:0] EOP_CODE  = 8'h7B;
    localparam logic [BYTE_W-1:0] CHAN_CODE = 8'h7C;
    localparam logic [BYTE_W-1:0] ESC_CODE  = 8'h7D;
    localparam logic [BYTE_W-1:0] FLIP_MASK = 8'h20;

    typedef enum logic [2:0] {
        TX_IDLE, TX_SOP, TX_CHM, TX_CHN, TX_EOP, TX_BYTE, TX_ESCB, TX_NEXT
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT, RX_CHM, RX_CHN, RX_PAY
    } rx_state_e;

    typedef struct packed {
        tx_state_e         st;
        logic [BYTE_W-1:0] hold;
        logic              last;
    } tx_regs_t;

    typedef struct packed {
        rx_state_e         st;
        logic              esc;
        logic              eop;
        logic              first;
        logic              drop;
        logic              ovalid;
        logic [BYTE_W-1:0] odata;
        logic              ofirst;
        logic              olast;
    } rx_regs_t;

    localparam tx_regs_t TX_RST = '{st: TX_IDLE, hold: '0, last: 1'b0};
    localparam rx_regs_t RX_RST = '{st: RX_HUNT, esc: 1'b0, eop: 1'b0, first: 1'b0,
                                    drop: 1'b0, ovalid: 1'b0, odata: '0,
                                    ofirst: 1'b0, olast: 1'b0};

    function automatic logic is_special(input logic [BYTE_W-1:0] b);
        return (b >= SOP_CODE) && (b <= ESC_CODE);
    endfunction

endpackage

// File: rtl/pkt_tx_encoder.sv
module pkt_tx_encoder
    import pkt_framer_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHAN_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    tx_regs_t q, d;
    logic     take;
    logic     new_pkt;

    always_comb begin
        d         = q;
        out_valid = 1'b0;
        out_data  = '0;
        in_ready  = 1'b0;
        take      = 1'b0;
        new_pkt   = (q.st == TX_IDLE) || q.last;
        case (q.st)
            TX_IDLE, TX_NEXT: take = 1'b1;
            TX_SOP: begin
                out_valid = 1'b1;
                out_data  = SOP_CODE;
                if (out_ready) d.st = TX_CHM;
            end
            TX_CHM: begin
                out_valid = 1'b1;
                out_data  = CHAN_CODE;
                if (out_ready) d.st = TX_CHN;
            end
            TX_CHN: begin
                out_valid = 1'b1;
                out_data  = CHAN_ID;
                if (out_ready) d.st = q.last ? TX_EOP : TX_BYTE;
            end
            TX_EOP: begin
                out_valid = 1'b1;
                out_data  = EOP_CODE;
                if (out_ready) d.st = TX_BYTE;
            end
            TX_BYTE: begin
                out_valid = 1'b1;
                out_data  = is_special(q.hold) ? ESC_CODE : q.hold;
                if (out_ready) begin
                    if (is_special(q.hold)) d.st = TX_ESCB;
                    else                    take = 1'b1;
                end
            end
            TX_ESCB: begin
                out_valid = 1'b1;
                out_data  = q.hold ^ FLIP_MASK;
                if (out_ready) take = 1'b1;
            end
            default: d.st = TX_IDLE;
        endcase

        if (take) begin
            in_ready = 1'b1;
            if (in_valid) begin
                d.hold = in_data;
                d.last = in_last;
                d.st   = new_pkt ? TX_SOP : (in_last ? TX_EOP : TX_BYTE);
            end else begin
                d.st   = new_pkt ? TX_IDLE : TX_NEXT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RST;
        else        q <= d;
    end

endmodule

// File: rtl/pkt_rx_decoder.sv
module pkt_rx_decoder
    import pkt_framer_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHAN_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_first,
    output logic              out_last,
    input  logic              out_ready
);

    rx_regs_t          q, d;
    logic              emit;
    logic [BYTE_W-1:0] val;

    always_comb begin
        d        = q;
        emit     = 1'b0;
        val      = in_data;
        in_ready = !q.ovalid || out_ready;
        if (out_ready) d.ovalid = 1'b0;

        if (in_valid && in_ready) begin
            if (in_data == SOP_CODE) begin
                d.st  = RX_CHM;
                d.esc = 1'b0;
                d.eop = 1'b0;
            end else begin
                case (q.st)
                    RX_HUNT: ;
                    RX_CHM: d.st = (in_data == CHAN_CODE) ? RX_CHN : RX_HUNT;
                    RX_CHN: begin
                        d.st    = RX_PAY;
                        d.drop  = (in_data != CHAN_ID);
                        d.first = 1'b1;
                        d.esc   = 1'b0;
                        d.eop   = 1'b0;
                    end
                    RX_PAY: begin
                        if (q.esc) begin
                            d.esc = 1'b0;
                            emit  = 1'b1;
                            val   = in_data ^ FLIP_MASK;
                        end else if (in_data == ESC_CODE) begin
                            d.esc = 1'b1;
                        end else if (in_data == EOP_CODE) begin
                            d.eop = 1'b1;
                        end else if (in_data != CHAN_CODE) begin
                            emit  = 1'b1;
                        end
                    end
                    default: d.st = RX_HUNT;
                endcase
            end
        end

        if (emit) begin
            d.first = 1'b0;
            if (q.eop) begin
                d.st  = RX_HUNT;
                d.eop = 1'b0;
            end
            if (!q.drop) begin
                d.ovalid = 1'b1;
                d.odata  = val;
                d.ofirst = q.first;
                d.olast  = q.eop;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign out_data  = q.odata;
    assign out_valid = q.ovalid;
    assign out_first = q.ofirst;
    assign out_last  = q.olast;

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_framer_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHAN_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_first,
    output logic              m_last,
    input  logic              m_ready
);

    pkt_tx_encoder #(.CHAN_ID(CHAN_ID)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (s_data),
        .in_valid  (s_valid),
        .in_last   (s_last),
        .in_ready  (s_ready),
        .out_data  (tx_data),
        .out_valid (tx_valid),
        .out_ready (tx_ready)
    );

    pkt_rx_decoder #(.CHAN_ID(CHAN_ID)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (rx_data),
        .in_valid  (rx_valid),
        .in_ready  (rx_ready),
        .out_data  (m_data),
        .out_valid (m_valid),
        .out_first (m_first),
        .out_last  (m_last),
        .out_ready (m_ready)
    );

endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk
    import pkt_framer_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHAN_ID = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [BYTE_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_first,
    input logic              m_last,
    input logic              m_ready
);

    logic [BYTE_W-1:0] prev_q;
    logic              have_q;
    logic              tx_hs;

    assign tx_hs = tx_valid && tx_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (tx_hs) begin
            prev_q <= tx_data;
            have_q <= 1'b1;
        end
    end

    // R2
    sop_then_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hs && have_q && prev_q == SOP_CODE) |-> (tx_data == CHAN_CODE));

    // R3
    marker_then_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hs && have_q && prev_q == CHAN_CODE) |-> (tx_data == CHAN_ID));

    // R4
    escape_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hs && have_q && prev_q == ESC_CODE) |-> (tx_data >= 8'h5A && tx_data <= 8'h5D));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R11
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_first) && $stable(m_last)));

endmodule

bind pkt_framer pkt_framer_chk #(.CHAN_ID(CHAN_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .m_data   (m_data),
    .m_valid  (m_valid),
    .m_first  (m_first),
    .m_last   (m_last),
    .m_ready  (m_ready)
);

// File: tb/pkt_framer_bench.sv
`timescale 1ns/1ps
module pkt_framer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic [7:0] m_data;
    logic       m_valid;
    logic       m_first;
    logic       m_last;
    logic       m_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit bp = 1'b0;
    int cyc = 0;

    logic [7:0] pay[$];
    logic [7:0] strm[$];
    logic [9:0] exp_q[$];
    logic [9:0] got_tx[$];
    logic [9:0] got_rx[$];

    pkt_framer u_pkt_framer (
        .clk(clk), .rst_n(rst_n),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .m_data(m_data), .m_valid(m_valid), .m_first(m_first), .m_last(m_last),
        .m_ready(m_ready)
    );

    always #10 clk = ~clk;

    // backpressure pattern on both output sides
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = !bp || (cyc % 3 != 0);
            m_ready  = !bp || (cyc % 4 != 1);
        end
    end

    // stream monitors
    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) got_tx.push_back({2'b00, tx_data});
        if (rst_n && m_valid && m_ready)   got_rx.push_back({m_first, m_last, m_data});
    end

    // R11: output hold under backpressure
    logic       tx_stall = 1'b0, rx_stall = 1'b0;
    logic [7:0] tx_held, rx_held;
    logic [1:0] rx_fl_held;
    always @(posedge clk) begin
        if (rst_n && tx_stall) begin
            checks++;
            if (!(tx_valid && tx_data == tx_held)) begin
                errors++;
                $display("FAIL R11 tx hold: actual v=%0b %h expected v=1 %h", tx_valid, tx_data, tx_held);
            end
        end
        if (rst_n && rx_stall) begin
            checks++;
            if (!(m_valid && m_data == rx_held && {m_first, m_last} == rx_fl_held)) begin
                errors++;
                $display("FAIL R11 rx hold: actual v=%0b %h expected v=1 %h", m_valid, m_data, rx_held);
            end
        end
        tx_stall   = rst_n && tx_valid && !tx_ready;
        tx_held    = tx_data;
        rx_stall   = rst_n && m_valid && !m_ready;
        rx_held    = m_data;
        rx_fl_held = {m_first, m_last};
    end

    function automatic void put_byte(input logic [7:0] b);
        if (b >= 8'h7A && b <= 8'h7D) begin
            strm.push_back(8'h7D);
            strm.push_back(b ^ 8'h20);
        end else begin
            strm.push_back(b);
        end
    endfunction

    function automatic void frame(input logic [7:0] chan);
        strm.push_back(8'h7A);
        strm.push_back(8'h7C);
        strm.push_back(chan);
        for (int i = 0; i < pay.size() - 1; i++) put_byte(pay[i]);
        strm.push_back(8'h7B);
        put_byte(pay[pay.size() - 1]);
    endfunction

    function automatic void strm_to_exp();
        foreach (strm[i]) exp_q.push_back({2'b00, strm[i]});
        strm.delete();
    endfunction

    function automatic void exp_pay();
        foreach (pay[i]) exp_q.push_back({i == 0, i == pay.size() - 1, pay[i]});
    endfunction

    function automatic logic [7:0] gen(input int n, input int k, input int j);
        if (j % 2 == 0) return 8'h78 + 8'((j + k + n) % 7);
        return 8'((n * 29 + k * 53 + j * 17) & 255);
    endfunction

    task automatic tx_push(input logic [7:0] b, input logic l);
        logic ok;
        @(negedge clk);
        s_valid = 1'b1; s_data = b; s_last = l;
        do begin
            #1 ok = s_ready;
            @(posedge clk);
            if (!ok) @(negedge clk);
        end while (!ok);
    endtask

    task automatic rx_push(input logic [7:0] b);
        logic ok;
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        do begin
            #1 ok = rx_ready;
            @(posedge clk);
            if (!ok) @(negedge clk);
        end while (!ok);
    endtask

    task automatic send_pay();
        foreach (pay[i]) tx_push(pay[i], i == pay.size() - 1);
    endtask

    task automatic send_strm();
        foreach (strm[i]) rx_push(strm[i]);
        strm.delete();
    endtask

    task automatic drain();
        @(negedge clk);
        s_valid = 1'b0; rx_valid = 1'b0;
        repeat (40) @(negedge clk);
        bp = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp(input string tag, input bit rx_side);
        logic [9:0] g[$];
        int n;
        g = rx_side ? got_rx : got_tx;
        checks++;
        if (g.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s length: actual %0d expected %0d", tag, g.size(), exp_q.size());
        end
        n = (g.size() < exp_q.size()) ? g.size() : exp_q.size();
        for (int i = 0; i < n; i++) begin
            checks++;
            if (g[i] !== exp_q[i]) begin
                errors++;
                $display("FAIL %s byte %0d: actual %h expected %h", tag, i, g[i], exp_q[i]);
            end
        end
        exp_q.delete(); got_tx.delete(); got_rx.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        checks++;
        if (tx_valid !== 1'b0 || m_valid !== 1'b0 || rx_ready !== 1'b1 || s_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: actual tv=%b mv=%b rr=%b sr=%b expected 0 0 1 1",
                     tx_valid, m_valid, rx_ready, s_ready);
        end

        // R5 R4: every single-byte payload
        for (int v = 0; v < 256; v++) begin
            pay.delete(); pay.push_back(8'(v));
            frame(8'h00); strm_to_exp();
            send_pay();
        end
        drain();
        cmp("R5 R4 tx single", 1'b0);

        // R2 R3 R4: multi-byte payloads under backpressure
        bp = 1'b1;
        for (int n = 2; n < 10; n++) begin
            for (int k = 0; k < 8; k++) begin
                pay.delete();
                for (int j = 0; j < n; j++) pay.push_back(gen(n, k, j));
                frame(8'h00); strm_to_exp();
                send_pay();
            end
        end
        pay.delete(); pay.push_back(8'h11); pay.push_back(8'h22); pay.push_back(8'h7A);
        frame(8'h00); strm_to_exp();
        send_pay();
        drain();
        cmp("R2 R3 R4 tx multi", 1'b0);

        // R6 R7: every single-byte packet decoded
        for (int v = 0; v < 256; v++) begin
            pay.delete(); pay.push_back(8'(v));
            frame(8'h00); exp_pay();
            send_strm();
        end
        drain();
        cmp("R6 R7 rx single", 1'b1);

        // R6 R7 R11: multi-byte packets under backpressure
        bp = 1'b1;
        for (int n = 2; n < 10; n++) begin
            for (int k = 0; k < 8; k++) begin
                pay.delete();
                for (int j = 0; j < n; j++) pay.push_back(gen(n, k + 3, j));
                frame(8'h00); exp_pay();
                send_strm();
            end
        end
        drain();
        cmp("R6 R7 R11 rx multi", 1'b1);

        // R8: non-zero channel dropped
        pay.delete(); pay.push_back(8'h01); pay.push_back(8'h7D); pay.push_back(8'h03);
        frame(8'h01);
        pay.delete(); pay.push_back(8'h44); pay.push_back(8'h7B);
        frame(8'h00); exp_pay();
        pay.delete(); pay.push_back(8'h55);
        frame(8'h80);
        send_strm();
        drain();
        cmp("R8 rx drop", 1'b1);

        // R9: start marker mid-packet aborts
        strm.push_back(8'h7A); strm.push_back(8'h7C); strm.push_back(8'h00);
        strm.push_back(8'h55); strm.push_back(8'h66); strm.push_back(8'h7B);
        exp_q.push_back({2'b10, 8'h55});
        exp_q.push_back({2'b00, 8'h66});
        pay.delete(); pay.push_back(8'h77); pay.push_back(8'h7D);
        frame(8'h00); exp_pay();
        send_strm();
        drain();
        cmp("R9 rx abort", 1'b1);

        // R10: bytes outside packets ignored
        strm.push_back(8'h11); strm.push_back(8'h7B); strm.push_back(8'h22);
        strm.push_back(8'h7D); strm.push_back(8'h33); strm.push_back(8'h7C);
        strm.push_back(8'h00); strm.push_back(8'h44);
        pay.delete(); pay.push_back(8'h09); pay.push_back(8'h08); pay.push_back(8'h07);
        frame(8'h00); exp_pay();
        strm.push_back(8'h05); strm.push_back(8'h06); strm.push_back(8'h7B);
        pay.delete(); pay.push_back(8'h7C);
        frame(8'h00); exp_pay();
        send_strm();
        drain();
        cmp("R10 rx outside", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule